// File: doc/BRIEF.md
# Dual-Mode Stack Pointer Unit

This block works out the memory address and the updated pointer for the stack operations of a processor with a 30-bit address space. The address is split into a 12-bit section and an 18-bit word. The stack pointer is a 36-bit word and can be read in two ways. When its upper half is positive and non-zero, and the program runs outside section 0, the pointer is a flat global address and steps by one. Otherwise the upper half is a count, the lower half is an offset inside the current program section, and both halves step together.

The core issues one operation at a time: push, pop, subroutine call, return, or stack adjust. It also supplies the current pointer, the 30-bit PC, a data word and a signed adjust amount. The unit makes at most one memory access for each operation, using a request/acknowledge handshake. When that access ends, it returns the new pointer, an overflow flag, the popped data word or the restored PC, and a one-cycle completion pulse. A call builds the stored return word itself from the PC.

Top module: `stack_ptr_unit`

## Requirements
- R1: The unit uses global mode when the PC section is non-zero, pointer bit 35 is 0 and the pointer's upper half (bits 35:18) is non-zero. In every other case it uses local mode, so section 0 is always local. The mode of the access appears on `mem_global` (1 = global).
- R2: In local mode the memory address is {PC section, lower half of the pointer used}. In global mode it is the low 30 bits of the pointer used.
- R3: Push and call address the pointer after its increment. Pop and return address the pointer as it was before the operation, and the pointer is decremented afterwards.
- R4: In local mode a step adds or subtracts 1 in each half separately. Each half wraps within 18 bits, and no carry or borrow passes between the halves.
- R5: In global mode a step adds or subtracts 1 on the whole 36-bit word, so a carry or borrow reaches the section bits.
- R6: A call stores bits 35:30 = 0, bits 29:18 = PC section and bits 17:0 = PC word + 1. The word wraps from 777777 octal to 0 and the section does not change.
- R7: A return sets `pc_out` to the low 30 bits of the word read from memory. A pop sets `rd_data` to the word read from memory.
- R8: `ovf` is set by a local push whose new upper half is 0, and by a local pop or return whose upper half was 0 before the decrement. A global operation or an adjust always clears it.
- R9: An adjust adds the signed 18-bit `adj_amount` to each half separately in local mode, or the sign-extended amount to the whole word in global mode. It makes no memory request and pulses `done` in the cycle after it is accepted.
- R10: `mem_req` rises in the cycle after an operation is accepted. It stays high, with address, write flag and write data unchanged, until the cycle in which `mem_ack` is sampled high. `done` pulses in the next cycle, and `op_ready` is low while the request is pending.
- R11: The operation codes are 1 push, 2 pop, 3 call, 4 return and 5 adjust. Push and call write (`mem_we` = 1) and pop and return read. Any other code is ignored: no request, no `done`, and the outputs do not change.
- R12: After reset, `op_ready` = 1, `mem_req` = 0, `done` = 0, and `sp_out`, `pc_out`, `rd_data` and `ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation offered |
| op_code | input | 3 | Operation code (R11) |
| op_ready | output | 1 | Unit can accept an operation |
| sp_in | input | 36 | Current stack pointer |
| pc_in | input | 30 | Current PC, section in bits 29:18 |
| data_in | input | 36 | Word to push |
| adj_amount | input | 18 | Signed adjust amount |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_global | output | 1 | Address mode of the access |
| mem_addr | output | 30 | Stack memory address |
| mem_wdata | output | 36 | Word to store |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 36 | Word read, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 36 | Updated stack pointer |
| pc_out | output | 30 | PC restored by the last return |
| rd_data | output | 36 | Word read by the last pop |
| ovf | output | 1 | Overflow of the last operation |

## Verification
The assertions assume that the memory raises `mem_ack` only while `mem_req` is high, and that `mem_rdata` is valid in the cycle of the acknowledge. The bench drives `mem_ack` only inside the request window, and it first holds the request unacknowledged for one cycle so that the hold rule is exercised. Operations are offered only while `op_ready` is high, and the PC, pointer and data inputs are changed only on the falling clock edge, so the values captured at acceptance are well defined.

// File: rtl/spu_pkg.sv
// Package spu_pkg: operation codes and FSM states shared by the stack pointer unit.
// Assumes every unit module is compiled after this package.
package spu_pkg;
    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4,
        OP_ADJ  = 3'd5
    } spu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MEM  = 1'b1
    } spu_state_e;

    // True for the codes the unit acts on.
    function automatic logic op_known(input logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd5);
    endfunction

    // True for operations that increment before storing.
    function automatic logic op_is_up(input spu_op_e op);
        return (op == OP_PUSH) || (op == OP_CALL);
    endfunction

    // True for operations that read and then decrement.
    function automatic logic op_is_down(input spu_op_e op);
        return (op == OP_POP) || (op == OP_RET);
    endfunction
endpackage

// File: rtl/spu_mode_detect.sv
// spu_mode_detect: decides whether the pointer is a flat global address
// or a count/offset pair. It assumes the pointer upper half is a
// two's-complement value and that section 0 must always be local.
module spu_mode_detect #(
    parameter int HALF_W = 18,
    parameter int SEC_W  = 12
) (
    input  logic [SEC_W-1:0]    pc_sec,
    input  logic [2*HALF_W-1:0] ptr,
    output logic                is_global
);
    logic [HALF_W-1:0] upper;

    // Global only for a positive, non-zero upper half outside section 0.
    always_comb begin
        upper     = ptr[2*HALF_W-1:HALF_W];
        is_global = (pc_sec != '0) && !upper[HALF_W-1] && (upper != '0);
    end
endmodule

// File: rtl/spu_ptr_arith.sv
// spu_ptr_arith: computes the next pointer, the stack address and the
// overflow condition for one operation. Local mode steps each half on its
// own; global mode steps the whole word. It assumes op is a known code.
module spu_ptr_arith
    import spu_pkg::*;
#(
    parameter int HALF_W = 18,
    parameter int SEC_W  = 12
) (
    input  spu_op_e                 op,
    input  logic                    is_global,
    input  logic [2*HALF_W-1:0]     ptr,
    input  logic [SEC_W-1:0]        pc_sec,
    input  logic [HALF_W-1:0]       adj,
    output logic [2*HALF_W-1:0]     next_ptr,
    output logic [SEC_W+HALF_W-1:0] addr,
    output logic                    ovf
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int ADDR_W = SEC_W + HALF_W;

    logic [HALF_W-1:0] delta;
    logic [WORD_W-1:0] delta_wide;
    logic [WORD_W-1:0] global_next;
    logic [WORD_W-1:0] local_next;
    logic [WORD_W-1:0] addr_ptr;

    // Signed step: +1 going up, -1 going down, the amount for an adjust.
    always_comb begin
        if (op_is_up(op))
            delta = HALF_W'(1);
        else if (op_is_down(op))
            delta = '1;
        else if (op == OP_ADJ)
            delta = adj;
        else
            delta = '0;
        delta_wide = {{HALF_W{delta[HALF_W-1]}}, delta};
    end

    // One adder per half for local mode, wrapping within the half.
    for (genvar h = 0; h < 2; h++) begin : g_half
        always_comb begin
            local_next[h*HALF_W +: HALF_W] = ptr[h*HALF_W +: HALF_W] + delta;
        end
    end

    // Full-width step for global mode.
    always_comb begin
        global_next = ptr + delta_wide;
    end

    // Pick the step rule, the pointer to address and form the address.
    always_comb begin
        next_ptr = is_global ? global_next : local_next;
        addr_ptr = op_is_up(op) ? next_ptr : ptr;
        if (is_global)
            addr = addr_ptr[ADDR_W-1:0];
        else
            addr = {pc_sec, addr_ptr[HALF_W-1:0]};
    end

    // Local count runs out: reaches zero going up, or was zero going down.
    always_comb begin
        ovf = 1'b0;
        if (!is_global) begin
            if (op_is_up(op) && next_ptr[WORD_W-1:HALF_W] == '0)
                ovf = 1'b1;
            else if (op_is_down(op) && ptr[WORD_W-1:HALF_W] == '0)
                ovf = 1'b1;
        end
    end
endmodule

// File: rtl/spu_link_word.sv
// spu_link_word: builds the return word stored by a call. The word number
// of the PC is incremented without carrying into the section, and the
// bits above the 30-bit address are cleared. No flags are included.
module spu_link_word #(
    parameter int HALF_W = 18,
    parameter int SEC_W  = 12
) (
    input  logic [SEC_W+HALF_W-1:0] pc,
    output logic [2*HALF_W-1:0]     link
);
    localparam int ADDR_W = SEC_W + HALF_W;
    localparam int PAD_W  = 2 * HALF_W - ADDR_W;

    logic [HALF_W-1:0] next_word;

    // Return address: next word in the same section, zero-padded.
    always_comb begin
        next_word = pc[HALF_W-1:0] + HALF_W'(1);
        link      = {{PAD_W{1'b0}}, pc[ADDR_W-1:HALF_W], next_word};
    end
endmodule

// File: rtl/stack_ptr_unit.sv
// stack_ptr_unit: top of the dual-mode stack pointer unit. It accepts one
// operation at a time, makes at most one request/acknowledge memory
// access, and returns the updated pointer, overflow, popped word or
// restored PC with a one-cycle done pulse. It assumes mem_ack is raised
// only while mem_req is high.
module stack_ptr_unit
    import spu_pkg::*;
#(
    parameter int HALF_W = 18,
    parameter int SEC_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_valid,
    input  logic [2:0]              op_code,
    output logic                    op_ready,
    input  logic [2*HALF_W-1:0]     sp_in,
    input  logic [SEC_W+HALF_W-1:0] pc_in,
    input  logic [2*HALF_W-1:0]     data_in,
    input  logic [HALF_W-1:0]       adj_amount,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic                    mem_global,
    output logic [SEC_W+HALF_W-1:0] mem_addr,
    output logic [2*HALF_W-1:0]     mem_wdata,
    input  logic                    mem_ack,
    input  logic [2*HALF_W-1:0]     mem_rdata,
    output logic                    done,
    output logic [2*HALF_W-1:0]     sp_out,
    output logic [SEC_W+HALF_W-1:0] pc_out,
    output logic [2*HALF_W-1:0]     rd_data,
    output logic                    ovf
);
    localparam int WORD_W = 2 * HALF_W;
    localparam int ADDR_W = SEC_W + HALF_W;

    spu_state_e        state;
    spu_op_e           op_now;
    spu_op_e           op_q;
    logic              accept;
    logic              is_global;
    logic [WORD_W-1:0] next_ptr;
    logic [ADDR_W-1:0] next_addr;
    logic              next_ovf;
    logic [WORD_W-1:0] link;
    logic [WORD_W-1:0] nsp_q;
    logic              ovf_q;
    logic [ADDR_W-1:0] addr_q;
    logic              glob_q;
    logic              we_q;
    logic [WORD_W-1:0] wdata_q;
    logic [SEC_W-1:0]  sec_q;

    // Decode the offered operation and the accept condition.
    always_comb begin
        op_now   = spu_op_e'(op_code);
        op_ready = (state == ST_IDLE);
        accept   = op_ready && op_valid && op_known(op_code);
    end

    spu_mode_detect #(.HALF_W(HALF_W), .SEC_W(SEC_W)) u_mode (
        .pc_sec   (pc_in[ADDR_W-1:HALF_W]),
        .ptr      (sp_in),
        .is_global(is_global)
    );

    spu_ptr_arith #(.HALF_W(HALF_W), .SEC_W(SEC_W)) u_arith (
        .op       (op_now),
        .is_global(is_global),
        .ptr      (sp_in),
        .pc_sec   (pc_in[ADDR_W-1:HALF_W]),
        .adj      (adj_amount),
        .next_ptr (next_ptr),
        .addr     (next_addr),
        .ovf      (next_ovf)
    );

    spu_link_word #(.HALF_W(HALF_W), .SEC_W(SEC_W)) u_link (
        .pc  (pc_in),
        .link(link)
    );

    // Sequencer: capture on accept, finish on acknowledge or at once for adjust.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            op_q    <= OP_NOP;
            nsp_q   <= '0;
            ovf_q   <= 1'b0;
            addr_q  <= '0;
            glob_q  <= 1'b0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            sec_q   <= '0;
            done    <= 1'b0;
            sp_out  <= '0;
            pc_out  <= '0;
            rd_data <= '0;
            ovf     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                op_q   <= op_now;
                glob_q <= is_global;
                sec_q  <= pc_in[ADDR_W-1:HALF_W];
                if (op_now == OP_ADJ) begin
                    sp_out <= next_ptr;
                    ovf    <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    state   <= ST_MEM;
                    nsp_q   <= next_ptr;
                    ovf_q   <= next_ovf;
                    addr_q  <= next_addr;
                    we_q    <= op_is_up(op_now);
                    wdata_q <= (op_now == OP_CALL) ? link : data_in;
                end
            end else if (state == ST_MEM && mem_ack) begin
                state  <= ST_IDLE;
                done   <= 1'b1;
                sp_out <= nsp_q;
                ovf    <= ovf_q;
                if (op_q == OP_POP)
                    rd_data <= mem_rdata;
                if (op_q == OP_RET)
                    pc_out <= mem_rdata[ADDR_W-1:0];
            end
        end
    end

    // Memory side is driven straight from the captured request.
    always_comb begin
        mem_req    = (state == ST_MEM);
        mem_we     = we_q;
        mem_global = glob_q;
        mem_addr   = addr_q;
        mem_wdata  = wdata_q;
    end

    // R10: request and its payload hold until acknowledged.
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));

    // R10: an acknowledge ends the request and completes the operation.
    a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> done && !mem_req);

    // R1: section 0 never produces a global access.
    a_r1_sec0_local: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && (sec_q == '0) |-> !mem_global);

    // R6: a call writes a word with the bits above the address cleared.
    a_r6_call_pad: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && (op_q == OP_CALL) |-> mem_we && (mem_wdata[WORD_W-1:ADDR_W] == '0));

    // R8: a completed global operation never reports overflow.
    a_r8_global_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        done && glob_q |-> !ovf);

    // R11: pops and returns only read.
    a_r11_read_kind: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && (op_q == OP_POP || op_q == OP_RET) |-> !mem_we);
endmodule

// File: tb/stack_ptr_unit_bench.sv
`timescale 1ns/1ps
module stack_ptr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic        op_ready;
    logic [35:0] sp_in = '0;
    logic [29:0] pc_in = '0;
    logic [35:0] data_in = '0;
    logic [17:0] adj_amount = '0;
    logic        mem_req, mem_we, mem_global;
    logic [29:0] mem_addr;
    logic [35:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [35:0] mem_rdata = '0;
    logic        done;
    logic [35:0] sp_out;
    logic [29:0] pc_out;
    logic [35:0] rd_data;
    logic        ovf;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    stack_ptr_unit u_stack_ptr_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_ready(op_ready), .sp_in(sp_in), .pc_in(pc_in), .data_in(data_in),
        .adj_amount(adj_amount), .mem_req(mem_req), .mem_we(mem_we),
        .mem_global(mem_global), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .sp_out(sp_out),
        .pc_out(pc_out), .rd_data(rd_data), .ovf(ovf)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  req;
        logic [35:0] sp;
        logic [29:0] pc;
        logic [35:0] din;
        logic [17:0] adj;
        logic [35:0] rdat;
        logic [29:0] eaddr;
        logic        eglob;
        logic [35:0] ewd;
        logic [35:0] esp;
        logic [29:0] epc;
        logic        eovf;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        // R4 local push, both halves +1
        '{3'd1, 8'd4, 36'o777770001000, 30'o0003000400, 36'o123456701234, 18'o0, 36'o0,
          30'o0003001001, 1'b0, 36'o123456701234, 36'o777771001001, 30'o0, 1'b0},
        // R8 local push, count reaches zero
        '{3'd1, 8'd8, 36'o777777002000, 30'o0003000400, 36'o000000000077, 18'o0, 36'o0,
          30'o0003002001, 1'b0, 36'o000000000077, 36'o000000002001, 30'o0, 1'b1},
        // R3 local pop addresses the old pointer
        '{3'd2, 8'd3, 36'o777770001005, 30'o0003000400, 36'o0, 18'o0, 36'o555000111222,
          30'o0003001005, 1'b0, 36'o0, 36'o777767001004, 30'o0, 1'b0},
        // R8 local pop with upper half zero
        '{3'd2, 8'd8, 36'o000000000100, 30'o0003000400, 36'o0, 18'o0, 36'o000111000222,
          30'o0003000100, 1'b0, 36'o0, 36'o777777000077, 30'o0, 1'b1},
        // R5 global push
        '{3'd1, 8'd5, 36'o000005000200, 30'o0003000400, 36'o707070707070, 18'o0, 36'o0,
          30'o0005000201, 1'b1, 36'o707070707070, 36'o000005000201, 30'o0, 1'b0},
        // R5 global push carries into the section
        '{3'd1, 8'd5, 36'o000005777777, 30'o0003000400, 36'o000000000001, 18'o0, 36'o0,
          30'o0006000000, 1'b1, 36'o000000000001, 36'o000006000000, 30'o0, 1'b0},
        // R5 global pop borrows from the section
        '{3'd2, 8'd5, 36'o000007000000, 30'o0003000400, 36'o0, 18'o0, 36'o222333444555,
          30'o0007000000, 1'b1, 36'o0, 36'o000006777777, 30'o0, 1'b0},
        // R6 local call stores padded PC+1
        '{3'd3, 8'd6, 36'o777760003000, 30'o0003000400, 36'o0, 18'o0, 36'o0,
          30'o0003003001, 1'b0, 36'o000003000401, 36'o777761003001, 30'o0, 1'b0},
        // R6 global call, PC word wraps inside section 4
        '{3'd3, 8'd6, 36'o000002000010, 30'o0004777777, 36'o0, 18'o0, 36'o0,
          30'o0002000011, 1'b1, 36'o000004000000, 36'o000002000011, 30'o0, 1'b0},
        // R7 local return restores the PC
        '{3'd4, 8'd7, 36'o777761003001, 30'o0003000400, 36'o0, 18'o0, 36'o770002123456,
          30'o0003003001, 1'b0, 36'o0, 36'o777760003000, 30'o0002123456, 1'b0},
        // R1 section 0 forces local mode despite a positive upper half
        '{3'd1, 8'd1, 36'o000003000500, 30'o0000000400, 36'o000000000005, 18'o0, 36'o0,
          30'o0000000501, 1'b0, 36'o000000000005, 36'o000004000501, 30'o0, 1'b0},
        // R9 local adjust by +8
        '{3'd5, 8'd9, 36'o777700001000, 30'o0003000400, 36'o0, 18'o000010, 36'o0,
          30'o0, 1'b0, 36'o0, 36'o777710001010, 30'o0, 1'b0},
        // R9 global adjust by -3
        '{3'd5, 8'd9, 36'o000004000005, 30'o0003000400, 36'o0, 18'o777775, 36'o0,
          30'o0, 1'b1, 36'o0, 36'o000004000002, 30'o0, 1'b0},
        // R9 global adjust borrows across the halves
        '{3'd5, 8'd9, 36'o000004000001, 30'o0003000400, 36'o0, 18'o777775, 36'o0,
          30'o0, 1'b1, 36'o0, 36'o000003777776, 30'o0, 1'b0},
        // R7 global return
        '{3'd4, 8'd7, 36'o000002000011, 30'o0004000000, 36'o0, 18'o0, 36'o000004000000,
          30'o0002000011, 1'b1, 36'o0, 36'o000002000010, 30'o0004000000, 1'b0},
        // R4 local push, lower half wraps with no carry upward
        '{3'd1, 8'd4, 36'o777770777777, 30'o0003000400, 36'o000000000011, 18'o0, 36'o0,
          30'o0003000000, 1'b0, 36'o000000000011, 36'o777771000000, 30'o0, 1'b0},
        // R9 local adjust in section 0, both halves wrap separately
        '{3'd5, 8'd9, 36'o000001000002, 30'o0000000400, 36'o0, 18'o777775, 36'o0,
          30'o0, 1'b0, 36'o0, 36'o777776777777, 30'o0, 1'b0}
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%o expected=%o", rq, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        string rq;
        logic [29:0] a0;
        rq = $sformatf("R%0d", v.req);
        @(negedge clk);
        op_valid = 1'b1; op_code = v.op; sp_in = v.sp; pc_in = v.pc;
        data_in = v.din; adj_amount = v.adj;
        @(negedge clk);
        op_valid = 1'b0;
        if (v.op == 3'd5) begin
            chk(!mem_req, "R9", "adjust request", 36'(mem_req), 36'd0);
            chk(done, "R9", "adjust done", 36'(done), 36'd1);
            chk(sp_out == v.esp, rq, "adjust sp", sp_out, v.esp);
            chk(!ovf, "R8", "adjust ovf", 36'(ovf), 36'd0);
            return;
        end
        chk(mem_req, "R10", "request raised", 36'(mem_req), 36'd1);
        chk(!op_ready, "R10", "ready low", 36'(op_ready), 36'd0);
        chk(mem_addr == v.eaddr, "R2", "address", 36'(mem_addr), 36'(v.eaddr));
        chk(mem_global == v.eglob, "R1", "mode", 36'(mem_global), 36'(v.eglob));
        chk(mem_we == (v.op == 3'd1 || v.op == 3'd3), "R11", "write flag",
            36'(mem_we), 36'(v.op == 3'd1 || v.op == 3'd3));
        if (v.op == 3'd1 || v.op == 3'd3)
            chk(mem_wdata == v.ewd, rq, "store word", mem_wdata, v.ewd);
        a0 = mem_addr;
        @(negedge clk);
        chk(mem_req && mem_addr == a0 && !done, "R10", "hold without ack",
            36'(mem_addr), 36'(a0));
        mem_ack = 1'b1; mem_rdata = v.rdat;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = '0;
        chk(done && !mem_req, "R10", "done after ack", 36'(done), 36'd1);
        chk(sp_out == v.esp, rq, "new sp", sp_out, v.esp);
        chk(ovf == v.eovf, (v.eovf ? "R8" : rq), "ovf", 36'(ovf), 36'(v.eovf));
        if (v.op == 3'd2)
            chk(rd_data == v.rdat, "R7", "pop data", rd_data, v.rdat);
        if (v.op == 3'd4)
            chk(pc_out == v.epc, "R7", "restored pc", 36'(pc_out), 36'(v.epc));
        @(negedge clk);
        chk(!done, "R10", "done one cycle", 36'(done), 36'd0);
    endtask

    initial begin
        logic [35:0] sp_keep;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(op_ready && !mem_req && !done, "R12", "control after reset",
            {33'd0, op_ready, mem_req, done}, 36'o4);
        chk(sp_out == '0 && pc_out == '0 && rd_data == '0 && !ovf, "R12",
            "data after reset", sp_out, 36'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);
        // R11 unknown codes are ignored
        sp_keep = sp_out;
        for (int c = 6; c <= 8; c++) begin
            @(negedge clk);
            op_valid = 1'b1; op_code = 3'(c % 8); sp_in = 36'o000005000005;
            pc_in = 30'o0003000400;
            @(negedge clk);
            op_valid = 1'b0;
            chk(!mem_req && !done && op_ready, "R11", "ignored code",
                36'(c % 8), 36'd0);
            chk(sp_out == sp_keep, "R11", "sp unchanged", sp_out, sp_keep);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule